// File: doc/BRIEF.md
# Frequency-Compensated Time-of-Day Counter

This block maintains a 64-bit time-of-day value for precision packet time stamping. On every source clock cycle a software-programmed addend is summed into a 32-bit phase accumulator. Each overflow of that accumulator advances the time counter by one tick, so the tick rate is the source rate scaled by addend / 2^32. Software trims the frequency by rewriting the addend while the counter runs. A bypass mode skips the accumulator and advances the counter on every source clock.

A 64-bit offset is added to the counter to form the reported time, which is presented continuously on a port and through the register interface. The 64-bit counter and offset are written through paired 32-bit registers. The low half is written first and staged, and the high-half write commits both halves in one cycle. Reads are also low half first. Reading a low half latches the matching high half, so the two halves always come from the same cycle.

The addend for a tick period P ns and a source frequency F MHz is ceil(2^32 * 1000 / (P * F)). A configuration is only legal when P * F / 1000 exceeds 1.0001, which keeps the addend below 2^32.

Top module: `ptpTimeCounter`

## Requirements
- R1: After reset the counter, accumulator and offset are zero, enable and bypass are off, read data is zero, and the addend reads back as ADDEND_RESET (0x8000_0000 by default).
- R2: With enable on and bypass off, each cycle adds the addend into the 32-bit accumulator (modulo 2^32), and the counter rises by exactly one in every cycle whose sum carries out of bit 31.
- R3: A write to the addend register (address 1) is used from the following cycle on and may be made while counting.
- R4: With enable and bypass both on, the counter rises by one on every cycle and the accumulator holds its value.
- R5: With enable off, neither counter nor accumulator changes, while every register can still be written and read.
- R6: Reads return data on regRdData one cycle after regRdEn. Reading address 2 returns counter bits 31:0 and latches bits 63:32, which a later read of address 3 returns.
- R7: A write to address 2 stages counter bits 31:0. A write to address 3 loads {data, staged} into the counter in one cycle, and this load replaces any increment in that cycle.
- R8: Address 4 stages offset bits 31:0, and a write to address 5 loads the full offset. timeNow equals counter + offset modulo 2^64. Reading address 6 returns time bits 31:0 and latches bits 63:32 for address 7. Addresses 4 and 5 read back the offset halves.
- R9: Writing the control register (address 0) with bit 2 set clears the counter, accumulator, offset and both staged halves. Enable and bypass take bits 0 and 1 of the same write.
- R10: Control register (address 0) layout: bit 0 enable, bit 1 bypass, bit 2 soft reset. Bit 2 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid the cycle after regRdEn |
| timeNow | output | 2*DATA_W | Counter plus offset |

## Verification
The accumulator is driven with an addend of exactly 2^31, which carries every second cycle, and with the ceiling addend for a ratio of 2.5, which carries at irregular intervals. It is also driven with an all-ones addend that is switched in while counting. Together these separate correct carry detection from off-by-one accumulation. Bypass runs are compared with disabled runs to show the counter moves only when enabled. A high-half counter load is placed next to a 32-bit low-word rollover to show the load overrides the increment and that the carry reaches the upper word. An all-ones offset checks that the reported time wraps modulo 2^64.

// File: rtl/ptpTimePkg.sv
package ptpTimePkg;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_ADDEND = 3'd1,
    ADR_CNT_LO = 3'd2,
    ADR_CNT_HI = 3'd3,
    ADR_OFF_LO = 3'd4,
    ADR_OFF_HI = 3'd5,
    ADR_TIM_LO = 3'd6,
    ADR_TIM_HI = 3'd7
  } regAddr_e;

  // strobes and mode bits handed from control to datapath
  typedef struct packed {
    logic     softRst;
    logic     addendWr;
    logic     cntLoWr;
    logic     cntHiWr;
    logic     offLoWr;
    logic     offHiWr;
    logic     rdStb;
    regAddr_e rdSel;
    logic     enable;
    logic     bypass;
  } tsStrobes_t;

endpackage

// File: rtl/ptpTimeCtrl.sv
module ptpTimeCtrl
  import ptpTimePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  regAddr_e   addr,
  input  logic [2:0] ctrlBits,
  output tsStrobes_t st
);

  logic enableQ, bypassQ;
  logic ctrlWr;

  assign ctrlWr = wrEn && (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      bypassQ <= 1'b0;
    end else if (ctrlWr) begin
      enableQ <= ctrlBits[0];
      bypassQ <= ctrlBits[1];
    end
  end

  always_comb begin
    st          = '0;
    st.softRst  = ctrlWr && ctrlBits[2];
    st.addendWr = wrEn && (addr == ADR_ADDEND);
    st.cntLoWr  = wrEn && (addr == ADR_CNT_LO);
    st.cntHiWr  = wrEn && (addr == ADR_CNT_HI);
    st.offLoWr  = wrEn && (addr == ADR_OFF_LO);
    st.offHiWr  = wrEn && (addr == ADR_OFF_HI);
    st.rdStb    = rdEn;
    st.rdSel    = addr;
    st.enable   = enableQ;
    st.bypass   = bypassQ;
  end

  // R10
  ctrl_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_CTRL) |=> (st.enable == $past(ctrlBits[0]) && st.bypass == $past(ctrlBits[1])));

endmodule

// File: rtl/ptpTimeDatapath.sv
module ptpTimeDatapath
  import ptpTimePkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] ADDEND_RESET = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tsStrobes_t            st,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [2*DATA_W-1:0]   timeNow
);

  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] accQ, addendQ, cntStageQ, offStageQ, cntSnapQ, timSnapQ, rdDataQ;
  logic [CNT_W-1:0]  cntQ, offQ;
  logic [DATA_W:0]   accSum;
  logic              tick;
  logic [DATA_W-1:0] rdNext;

  assign accSum  = {1'b0, accQ} + {1'b0, addendQ};
  assign tick    = st.enable && (st.bypass || accSum[DATA_W]);
  assign timeNow = cntQ + offQ;
  assign rdData  = rdDataQ;

  // phase accumulator and addend
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      addendQ <= ADDEND_RESET;
    end else begin
      if (st.softRst)
        accQ <= '0;
      else if (st.enable && !st.bypass)
        accQ <= accSum[DATA_W-1:0];
      if (st.addendWr)
        addendQ <= wrData;
    end
  end

  // time counter with staged low half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      cntStageQ <= '0;
    end else begin
      if (st.softRst)
        cntQ <= '0;
      else if (st.cntHiWr)
        cntQ <= {wrData, cntStageQ};
      else if (tick)
        cntQ <= cntQ + 1'b1;
      if (st.softRst)
        cntStageQ <= '0;
      else if (st.cntLoWr)
        cntStageQ <= wrData;
    end
  end

  // offset with staged low half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ      <= '0;
      offStageQ <= '0;
    end else begin
      if (st.softRst)
        offQ <= '0;
      else if (st.offHiWr)
        offQ <= {wrData, offStageQ};
      if (st.softRst)
        offStageQ <= '0;
      else if (st.offLoWr)
        offStageQ <= wrData;
    end
  end

  // read mux
  always_comb begin
    case (st.rdSel)
      ADR_CTRL:   rdNext = {{(DATA_W-2){1'b0}}, st.bypass, st.enable};
      ADR_ADDEND: rdNext = addendQ;
      ADR_CNT_LO: rdNext = cntQ[DATA_W-1:0];
      ADR_CNT_HI: rdNext = cntSnapQ;
      ADR_OFF_LO: rdNext = offQ[DATA_W-1:0];
      ADR_OFF_HI: rdNext = offQ[CNT_W-1:DATA_W];
      ADR_TIM_LO: rdNext = timeNow[DATA_W-1:0];
      default:    rdNext = timSnapQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      cntSnapQ <= '0;
      timSnapQ <= '0;
    end else if (st.rdStb) begin
      rdDataQ <= rdNext;
      if (st.rdSel == ADR_CNT_LO) cntSnapQ <= cntQ[CNT_W-1:DATA_W];
      if (st.rdSel == ADR_TIM_LO) timSnapQ <= timeNow[CNT_W-1:DATA_W];
    end
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.enable && !st.softRst && !st.cntHiWr) |=> $stable(cntQ));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.enable && !st.softRst && !st.cntHiWr) |=> ((cntQ - $past(cntQ)) <= 1));

  // R4
  byp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.enable && st.bypass && !st.softRst && !st.cntHiWr) |=> (cntQ == $past(cntQ) + 1'b1));

  // R4
  acc_byp_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st.bypass || !st.enable) && !st.softRst) |=> $stable(accQ));

  // R9
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.softRst |=> (cntQ == '0 && offQ == '0 && accQ == '0));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.cntHiWr && !st.softRst) |=> (cntQ == {$past(wrData), $past(cntStageQ)}));

endmodule

// File: rtl/ptpTimeCounter.sv
module ptpTimeCounter
  import ptpTimePkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] ADDEND_RESET = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [2:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [2*DATA_W-1:0] timeNow
);

  tsStrobes_t st;

  ptpTimeCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .rdEn     (regRdEn),
    .addr     (regAddr_e'(regAddr)),
    .ctrlBits (regWrData[2:0]),
    .st       (st)
  );

  ptpTimeDatapath #(
    .DATA_W       (DATA_W),
    .ADDEND_RESET (ADDEND_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .timeNow (timeNow)
  );

endmodule

// File: tb/ptpTimeCounter_tb.sv
module ptpTimeCounter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] timeNow;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ptpTimeCounter u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .timeNow(timeNow)
  );

  // behavioural reference
  longint unsigned mCnt, mOff, mSum;
  int unsigned mAcc, mAddend, mCntStage, mOffStage, mSnap, mTSnap, mRd;
  bit mEn, mByp;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mOff = 0; mAcc = 0; mAddend = 32'h8000_0000;
      mCntStage = 0; mOffStage = 0; mSnap = 0; mTSnap = 0; mRd = 0;
      mEn = 0; mByp = 0;
    end else begin
      longint unsigned nCnt, tNow;
      int unsigned nAcc;
      tNow = mCnt + mOff;
      if (regRdEn) begin
        case (regAddr)
          3'd0: mRd = {30'd0, mByp, mEn};
          3'd1: mRd = mAddend;
          3'd2: begin mRd = mCnt[31:0]; mSnap = mCnt[63:32]; end
          3'd3: mRd = mSnap;
          3'd4: mRd = mOff[31:0];
          3'd5: mRd = mOff[63:32];
          3'd6: begin mRd = tNow[31:0]; mTSnap = tNow[63:32]; end
          default: mRd = mTSnap;
        endcase
      end
      mSum = longint'(mAcc) + longint'(mAddend);
      nAcc = (mEn && !mByp) ? mSum[31:0] : mAcc;
      nCnt = (mEn && (mByp || mSum[32])) ? mCnt + 1 : mCnt;
      if (regWrEn) begin
        case (regAddr)
          3'd0: begin
            mEn = regWrData[0]; mByp = regWrData[1];
            if (regWrData[2]) begin
              nCnt = 0; nAcc = 0; mOff = 0; mCntStage = 0; mOffStage = 0;
            end
          end
          3'd1: mAddend = regWrData;
          3'd2: mCntStage = regWrData;
          3'd3: nCnt = {regWrData, mCntStage};
          3'd4: mOffStage = regWrData;
          3'd5: mOff = {regWrData, mOffStage};
          default: ;
        endcase
      end
      mCnt = nCnt;
      mAcc = nAcc;
    end
  end

  task automatic check(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(timeNow == mCnt + mOff, "R2 R8 timeNow vs model", timeNow, mCnt + mOff);
      check(regRdData == mRd, "R6 regRdData vs model", regRdData, mRd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    v = regRdData;
    regRdEn = 1'b0;
  endtask

  function automatic longint unsigned addendFor(input longint unsigned periodNs, input longint unsigned freqMhz);
    longint unsigned num, den;
    num = (64'd1 << 32) * 1000;
    den = periodNs * freqMhz;
    return (num + den - 1) / den;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(timeNow == 0, "R1 timeNow after reset", timeNow, 0);
    check(regRdData == 0, "R1 read data after reset", regRdData, 0);
    rd(3'd1, v); check(v == 32'h8000_0000, "R1 addend reset value", v, 32'h8000_0000);
    rd(3'd0, v); check(v == 0, "R1 control after reset", v, 0);

    // R2 addend 2^31 (8 ns tick, 250 MHz) carries every other cycle
    wr(3'd1, 32'(addendFor(8, 250)));
    wr(3'd0, 32'h5);
    idle(20);
    check(timeNow == 10, "R2 half-rate count", timeNow, 10);

    // R3 ratio 2.5 addend, then a runtime change
    wr(3'd0, 32'h4);
    wr(3'd1, 32'(addendFor(10, 250)));
    wr(3'd0, 32'h5);
    idle(25);
    check(timeNow == 10, "R3 ratio 2.5 count", timeNow, 10);
    wr(3'd1, 32'hFFFF_FFFF);
    idle(8);
    rd(3'd1, v); check(v == 32'hFFFF_FFFF, "R3 addend readback", v, 32'hFFFF_FFFF);

    // R4 bypass
    wr(3'd0, 32'h7);
    idle(16);
    check(timeNow == 16, "R4 bypass count", timeNow, 16);

    // R5 disabled hold, registers still accessible
    wr(3'd0, 32'h0);
    t0 = timeNow;
    idle(10);
    check(timeNow == t0, "R5 hold while disabled", timeNow, t0);
    wr(3'd2, 32'h9ABC_DEF0);
    wr(3'd3, 32'h1234_5678);
    check(timeNow == 64'h1234_5678_9ABC_DEF0, "R5 R7 load while disabled", timeNow, 64'h1234_5678_9ABC_DEF0);
    rd(3'd2, v); check(v == 32'h9ABC_DEF0, "R6 low read", v, 32'h9ABC_DEF0);
    rd(3'd3, v); check(v == 32'h1234_5678, "R6 high read", v, 32'h1234_5678);

    // R6 coherent read while running
    wr(3'd0, 32'h3);
    rd(3'd2, v);
    idle(5);
    rd(3'd3, v); check(v == 32'h1234_5678, "R6 latched high while running", v, 32'h1234_5678);

    // R7 load overrides increment, carry into upper word
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'h0000_0001);
    check(timeNow == 64'h1_FFFF_FFFE, "R7 load replaces increment", timeNow, 64'h1_FFFF_FFFE);
    idle(2);
    check(timeNow == 64'h2_0000_0000, "R7 carry into high word", timeNow, 64'h2_0000_0000);

    // R8 offset wraps modulo 2^64
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h5);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    check(timeNow == 64'h4, "R8 offset wrap", timeNow, 4);
    rd(3'd6, v); check(v == 32'h4, "R8 time low read", v, 4);
    rd(3'd7, v); check(v == 32'h0, "R8 time high read", v, 0);
    rd(3'd4, v); check(v == 32'hFFFF_FFFF, "R8 offset low readback", v, 32'hFFFF_FFFF);

    // R9 soft reset clears counter and offset
    wr(3'd0, 32'h4);
    check(timeNow == 0, "R9 soft reset clears time", timeNow, 0);
    rd(3'd5, v); check(v == 0, "R9 offset cleared", v, 0);
    rd(3'd0, v); check(v == 0, "R9 R10 bit 2 reads zero", v, 0);

    // R10 control layout
    wr(3'd0, 32'h3);
    rd(3'd0, v); check(v == 32'h3, "R10 enable and bypass bits", v, 3);
    wr(3'd0, 32'h1);
    rd(3'd0, v); check(v == 32'h1, "R10 enable only", v, 1);
    idle(6);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule